// File: doc/BRIEF.md
# Flash Self-Programming Command Sequencer

This block sits between a CPU and its own program flash. It turns a two-step software ritual into flash operations. Software first writes a command byte into a control register. It then issues a store strobe that carries a word address and a data word. The strobe only counts if it arrives inside a short window after the control write. The command byte picks one of five actions: load one word into a page-sized staging buffer, erase a page, program a page from the buffer, tighten the boot-lock bits, or clear the sticky busy flag.

Erase and program are passed to the flash array through a request/done handshake, so the array's own busy time decides how long they last. Pages are split into two regions. A page number below `NRWW_BASE` belongs to the read-while-write region: a busy flag is raised and stays up until software clears it, and CPU reads of that region are refused while the flag is up. A page at or above `NRWW_BASE` belongs to the no-read-while-write region: the CPU is stalled for the whole operation. A level interrupt tells software that the sequencer is free again.

Top module: `spm_seq`

## Requirements
- R1: The control byte drives the block. Bit 7 is the interrupt enable and is stored on every control write. The low seven bits select the action: 7'h01 is buffer fill (only when bit 7 is 0), 7'h03 is page erase, 7'h05 is page write, 7'h09 is lock set and 7'h11 is re-enable. Any other value, including 8'h81, starts nothing. Fill, erase, write and lock set raise `en_o` on the next edge.
- R2: A store strobe is taken only when it is sampled 1 to `WINDOW` cycles after the control write was sampled. If no strobe arrives, `en_o` clears on the `WINDOW`th edge and a later strobe has no effect.
- R3: An accepted erase or write raises `fl_req_o` on the acceptance edge. `fl_erase_o` is 1 for erase and 0 for write, and `fl_page_o` is taken from `spm_addr_i[ADDR_W-1:PAGE_IDX_W]`; the word bits and the data word are ignored. `fl_req_o` and `en_o` stay high until the edge on which `fl_done_i` is sampled, and both are low after that edge.
- R4: An erase or write to a page below `NRWW_BASE` sets `rww_busy_o` on the acceptance edge. The flag stays set after the operation completes. Only a re-enable control write clears it.
- R5: An erase or write to a page at or above `NRWW_BASE` holds `cpu_stall_o` high from the acceptance edge until the done edge, and leaves `rww_busy_o` alone. A read-while-write operation never stalls the CPU.
- R6: `irq_o` is a level. It is high one cycle after the interrupt enable is 1 while `en_o` is 0. It stays high for as long as that holds, and it is low while an operation is in progress.
- R7: `lock_o` resets to 4'b1111. An accepted lock set loads `lock_o & spm_data_i[5:2]`, so a lock bit can only move from 1 to 0.
- R8: An accepted fill stores `spm_data_i` at buffer word `spm_addr_i[PAGE_IDX_W-1:0]`. Only the first fill of a word after the buffer is cleared takes effect. `fl_rd_data_o` returns the word at `fl_rd_idx_i` one cycle later, and an unwritten word reads all ones.
- R9: The buffer is cleared by reset, by a completed page write and by a re-enable write. A completed erase does not clear it.
- R10: A read with `rd_en_i` high to a page below `NRWW_BASE`, while `rww_busy_o` is high, returns `BAD_WORD` on `rd_data_o` with `rd_viol_o` high one cycle later. Any other read returns `arr_rdata_i` with `rd_viol_o` low.
- R11: After reset, `en_o`, `fl_req_o`, `rww_busy_o`, `cpu_stall_o`, `irq_o` and `rd_viol_o` are 0 and `lock_o` is 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control byte |
| en_o | output | 1 | Command enable, armed or operation in progress |
| spm_stb_i | input | 1 | Store-to-program-memory strobe |
| spm_addr_i | input | ADDR_W | Word address: page number above word index |
| spm_data_i | input | DATA_W | Data word of the store |
| fl_req_o | output | 1 | Flash operation request, held until done |
| fl_erase_o | output | 1 | 1 = erase, 0 = program from buffer |
| fl_page_o | output | PAGE_NUM_W | Target page of the flash operation |
| fl_done_i | input | 1 | Flash operation finished, one-cycle pulse |
| fl_rd_idx_i | input | PAGE_IDX_W | Buffer word index read by the array |
| fl_rd_data_o | output | DATA_W | Buffer word, one cycle after index |
| rww_busy_o | output | 1 | Sticky read-while-write busy flag |
| cpu_stall_o | output | 1 | CPU halt during no-read-while-write operation |
| irq_o | output | 1 | Level interrupt: sequencer free |
| lock_o | output | 4 | Boot lock bits, 0 = protected |
| rd_en_i | input | 1 | CPU program-memory read |
| rd_addr_i | input | ADDR_W | CPU read word address |
| arr_rdata_i | input | DATA_W | Word returned by the flash array |
| rd_data_o | output | DATA_W | Guarded read data |
| rd_viol_o | output | 1 | Read refused by busy region |

## Verification
The bench uses the default build: 8-word pages (`PAGE_IDX_W`=3), 16 pages (`PAGE_NUM_W`=4), `NRWW_BASE`=12, a `WINDOW` of 4 and `BAD_WORD`=16'hBAD0. With a window this small, both edges of the timed window can be driven exactly: a strobe on the fourth cycle is taken and one on the fifth is refused. With eight buffer words, a table of fill vectors can give each case its own word, so write-once and rejection show up in the buffer read-back. The page split puts both regions within reach of short addresses: page 2 and page 3 for the busy-flag and read-refusal path, pages 13 and 14 for the stall path.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_FILL, OP_ERASE, OP_PWRITE, OP_LOCK, OP_RWWEN
  } spm_op_e;

  typedef enum logic {ST_IDLE, ST_FLASH} spm_state_e;

  function automatic spm_op_e spm_decode(input logic [7:0] b);
    spm_op_e op;
    case (b[6:0])
      7'h01:   op = b[7] ? OP_NONE : OP_FILL;
      7'h03:   op = OP_ERASE;
      7'h05:   op = OP_PWRITE;
      7'h09:   op = OP_LOCK;
      7'h11:   op = OP_RWWEN;
      default: op = OP_NONE;
    endcase
    return op;
  endfunction
endpackage

// File: rtl/spm_win_timer.sv
module spm_win_timer #(
  parameter int WINDOW = 4,
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic take,
  output logic open,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (arm)         cnt <= CNT_W'(WINDOW);
    else if (take)        cnt <= '0;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign open = (cnt != '0);
  assign last = (cnt == CNT_W'(1));

  // R2: once the window is closed it stays closed until the next arm
  p_closed_stays_r2: assert property (@(posedge clk) disable iff (rst)
    (!open && !arm) |=> !open);
endmodule

// File: rtl/spm_page_buf.sv
module spm_page_buf #(
  parameter int PAGE_IDX_W = 3,
  parameter int DATA_W     = 16,
  localparam int WORDS     = 1 << PAGE_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  we,
  input  logic [PAGE_IDX_W-1:0] widx,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [PAGE_IDX_W-1:0] ridx,
  output logic [DATA_W-1:0]     rdata
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  filled;
  logic [DATA_W-1:0] mem_q;
  logic              filled_q;
  logic              wr_ok;

  assign wr_ok = we && !filled[widx];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[widx] <= wdata;
    mem_q <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      filled   <= '0;
      filled_q <= 1'b0;
    end else begin
      if (wr_ok) filled[widx] <= 1'b1;
      filled_q <= filled[ridx];
    end
  end

  assign rdata = filled_q ? mem_q : '1;

  // R8: a slot that holds a word keeps it until clear
  p_fill_once_r8: assert property (@(posedge clk) disable iff (rst)
    (filled[widx] && we && !clear) |=> filled[$past(widx)]);
endmodule

// File: rtl/spm_rd_guard.sv
module spm_rd_guard #(
  parameter int PAGE_NUM_W = 4,
  parameter int DATA_W     = 16,
  parameter int NRWW_BASE  = 12,
  parameter logic [DATA_W-1:0] BAD_WORD = '0,
  localparam logic [PAGE_NUM_W-1:0] NRWW_PG = PAGE_NUM_W'(NRWW_BASE)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [PAGE_NUM_W-1:0] rd_page,
  input  logic                  busy,
  input  logic [DATA_W-1:0]     arr_rdata,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_viol
);
  logic refuse;
  assign refuse = rd_en && busy && (rd_page < NRWW_PG);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_viol <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_viol <= refuse;
      rd_data <= refuse ? BAD_WORD : arr_rdata;
    end
  end

  // R10: a refusal only follows a cycle in which the busy flag was up
  p_viol_needs_busy_r10: assert property (@(posedge clk) disable iff (rst)
    rd_viol |-> $past(busy));
endmodule

// File: rtl/spm_seq.sv
module spm_seq
  import spm_pkg::*;
#(
  parameter int PAGE_IDX_W = 3,
  parameter int PAGE_NUM_W = 4,
  parameter int DATA_W     = 16,
  parameter int NRWW_BASE  = 12,
  parameter int WINDOW     = 4,
  parameter logic [DATA_W-1:0] BAD_WORD = 16'hBAD0,
  localparam int ADDR_W    = PAGE_NUM_W + PAGE_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctl_we_i,
  input  logic [7:0]            ctl_wdata_i,
  output logic                  en_o,
  input  logic                  spm_stb_i,
  input  logic [ADDR_W-1:0]     spm_addr_i,
  input  logic [DATA_W-1:0]     spm_data_i,
  output logic                  fl_req_o,
  output logic                  fl_erase_o,
  output logic [PAGE_NUM_W-1:0] fl_page_o,
  input  logic                  fl_done_i,
  input  logic [PAGE_IDX_W-1:0] fl_rd_idx_i,
  output logic [DATA_W-1:0]     fl_rd_data_o,
  output logic                  rww_busy_o,
  output logic                  cpu_stall_o,
  output logic                  irq_o,
  output logic [3:0]            lock_o,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  input  logic [DATA_W-1:0]     arr_rdata_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  rd_viol_o
);
  localparam logic [PAGE_NUM_W-1:0] NRWW_PG = PAGE_NUM_W'(NRWW_BASE);

  spm_state_e state;
  spm_op_e    op_d, cmd_r;
  logic       ie_r;
  logic       arm, take, expire, win_open, win_last;
  logic       buf_we, buf_clr;
  logic [PAGE_NUM_W-1:0] stb_page;

  always_comb op_d = spm_decode(ctl_wdata_i);

  assign stb_page = spm_addr_i[ADDR_W-1:PAGE_IDX_W];
  assign arm    = ctl_we_i && (state == ST_IDLE) &&
                  (op_d inside {OP_FILL, OP_ERASE, OP_PWRITE, OP_LOCK});
  assign take   = en_o && (state == ST_IDLE) && win_open && spm_stb_i && !ctl_we_i;
  assign expire = win_last && !take && !arm;

  spm_win_timer #(.WINDOW(WINDOW)) u_win (
    .clk(clk), .rst(rst), .arm(arm), .take(take),
    .open(win_open), .last(win_last)
  );

  assign buf_we  = take && (cmd_r == OP_FILL);
  assign buf_clr = ((state == ST_FLASH) && fl_done_i && !fl_erase_o) ||
                   (ctl_we_i && (state == ST_IDLE) && (op_d == OP_RWWEN));

  spm_page_buf #(.PAGE_IDX_W(PAGE_IDX_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .clear(buf_clr), .we(buf_we),
    .widx(spm_addr_i[PAGE_IDX_W-1:0]), .wdata(spm_data_i),
    .ridx(fl_rd_idx_i), .rdata(fl_rd_data_o)
  );

  spm_rd_guard #(.PAGE_NUM_W(PAGE_NUM_W), .DATA_W(DATA_W),
                 .NRWW_BASE(NRWW_BASE), .BAD_WORD(BAD_WORD)) u_guard (
    .clk(clk), .rst(rst), .rd_en(rd_en_i),
    .rd_page(rd_addr_i[ADDR_W-1:PAGE_IDX_W]), .busy(rww_busy_o),
    .arr_rdata(arr_rdata_i), .rd_data(rd_data_o), .rd_viol(rd_viol_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cmd_r       <= OP_NONE;
      ie_r        <= 1'b0;
      en_o        <= 1'b0;
      irq_o       <= 1'b0;
      fl_req_o    <= 1'b0;
      fl_erase_o  <= 1'b0;
      fl_page_o   <= '0;
      rww_busy_o  <= 1'b0;
      cpu_stall_o <= 1'b0;
      lock_o      <= 4'b1111;
    end else begin
      irq_o <= ie_r && !en_o;
      if (ctl_we_i) ie_r <= ctl_wdata_i[7];
      case (state)
        ST_IDLE: begin
          if (ctl_we_i) begin
            en_o  <= arm;
            cmd_r <= op_d;
            if (op_d == OP_RWWEN) rww_busy_o <= 1'b0;
          end else if (take) begin
            case (cmd_r)
              OP_FILL: en_o <= 1'b0;
              OP_LOCK: begin
                lock_o <= lock_o & spm_data_i[5:2];
                en_o   <= 1'b0;
              end
              OP_ERASE, OP_PWRITE: begin
                state      <= ST_FLASH;
                fl_req_o   <= 1'b1;
                fl_erase_o <= (cmd_r == OP_ERASE);
                fl_page_o  <= stb_page;
                if (stb_page >= NRWW_PG) cpu_stall_o <= 1'b1;
                else                     rww_busy_o  <= 1'b1;
              end
              default: en_o <= 1'b0;
            endcase
          end else if (expire) begin
            en_o <= 1'b0;
          end
        end
        ST_FLASH: begin
          if (fl_done_i) begin
            state       <= ST_IDLE;
            fl_req_o    <= 1'b0;
            cpu_stall_o <= 1'b0;
            en_o        <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: request is held until the array reports done
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (fl_req_o && !fl_done_i) |=> fl_req_o);
  // R3: enable stays up for the whole operation
  p_en_during_op_r3: assert property (@(posedge clk) disable iff (rst)
    fl_req_o |-> en_o);
  // R4: busy flag survives everything except a re-enable write
  p_busy_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (rww_busy_o && !(ctl_we_i && op_d == OP_RWWEN)) |=> rww_busy_o);
  // R5: stall only during an operation on the no-read-while-write region
  p_stall_nrww_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_stall_o |-> (fl_req_o && fl_page_o >= NRWW_PG));
  // R6: interrupt is quiet while an operation runs
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    fl_req_o |-> !irq_o);
  // R7: lock bits never move back toward unprotected
  p_lock_mono_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_o & ~$past(lock_o)) == 4'b0000);
endmodule

// File: tb/spm_seq_test.sv
module spm_seq_test;
  localparam int IW = 3;
  localparam int PW = 4;
  localparam int AW = IW + PW;
  localparam logic [15:0] BAD = 16'hBAD0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic en;
  logic stb = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic [15:0] sdata = '0;
  logic fl_req, fl_erase, fl_done = 1'b0;
  logic [PW-1:0] fl_page;
  logic [IW-1:0] fl_rd_idx = '0;
  logic [15:0] fl_rd_data;
  logic busy, stall, irq;
  logic [3:0] lock;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0] arr_rdata = '0;
  logic [15:0] rd_data;
  logic rd_viol;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spm_seq uut (
    .clk(clk), .rst(rst), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .en_o(en),
    .spm_stb_i(stb), .spm_addr_i(saddr), .spm_data_i(sdata),
    .fl_req_o(fl_req), .fl_erase_o(fl_erase), .fl_page_o(fl_page), .fl_done_i(fl_done),
    .fl_rd_idx_i(fl_rd_idx), .fl_rd_data_o(fl_rd_data),
    .rww_busy_o(busy), .cpu_stall_o(stall), .irq_o(irq), .lock_o(lock),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .arr_rdata_i(arr_rdata),
    .rd_data_o(rd_data), .rd_viol_o(rd_viol)
  );

  typedef struct packed {
    logic [7:0]  ctl;
    logic [2:0]  gap;
    logic [2:0]  idx;
    logic [15:0] data;
    logic [15:0] expw;
  } vec_t;

  // fill vectors, all on page 0; expw is the word expected at idx afterwards
  localparam vec_t VEC [8] = '{
    '{8'h01, 3'd1, 3'd0, 16'h1111, 16'h1111},
    '{8'h01, 3'd4, 3'd1, 16'h2222, 16'h2222},
    '{8'h01, 3'd5, 3'd2, 16'h3333, 16'hFFFF},
    '{8'h81, 3'd1, 3'd3, 16'h4444, 16'hFFFF},
    '{8'h00, 3'd1, 3'd4, 16'h5151, 16'hFFFF},
    '{8'h01, 3'd2, 3'd0, 16'h9999, 16'h1111},
    '{8'h01, 3'd3, 3'd5, 16'h5555, 16'h5555},
    '{8'h21, 3'd1, 3'd6, 16'h6666, 16'hFFFF}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] b);
    ctl_we = 1'b1; ctl_wdata = b; tick(); ctl_we = 1'b0;
  endtask

  task automatic issue(input logic [7:0] b, input int gap,
                       input logic [AW-1:0] a, input logic [15:0] d);
    ctl_write(b);
    repeat (gap - 1) tick();
    stb = 1'b1; saddr = a; sdata = d; tick(); stb = 1'b0;
  endtask

  task automatic flash_finish(input int busy_cycles);
    repeat (busy_cycles) tick();
    fl_done = 1'b1; tick(); fl_done = 1'b0;
  endtask

  task automatic buf_read(input logic [IW-1:0] i, output logic [15:0] w);
    fl_rd_idx = i; tick(); w = fl_rd_data;
  endtask

  task automatic cpu_read(input logic [AW-1:0] a, input logic [15:0] arr);
    rd_en = 1'b1; rd_addr = a; arr_rdata = arr; tick(); rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    chk("R11 en", 16'(en), 16'h0);
    chk("R11 req", 16'(fl_req), 16'h0);
    chk("R11 busy", 16'(busy), 16'h0);
    chk("R11 stall", 16'(stall), 16'h0);
    chk("R11 irq", 16'(irq), 16'h0);
    chk("R11 viol", 16'(rd_viol), 16'h0);
    chk("R11 lock", 16'(lock), 16'h000F);

    // R1 R2 R8: fill vectors, window edges, decode, write-once
    for (int k = 0; k < 8; k++) begin
      issue(VEC[k].ctl, int'(VEC[k].gap), {4'd0, VEC[k].idx}, VEC[k].data);
      chk("R2 en after fill vector", 16'(en), 16'h0);
      buf_read(VEC[k].idx, w);
      chk("R1/R8 fill vector word", w, VEC[k].expw);
    end

    // R2: enable self-clears on the 4th cycle without a strobe
    ctl_write(8'h01);
    repeat (3) tick();
    chk("R2 en still armed cycle 3", 16'(en), 16'h1);
    tick();
    chk("R2 en expired", 16'(en), 16'h0);

    // R3 R4: erase of read-while-write page 2, word bits and data ignored
    issue(8'h03, 1, {4'd2, 3'd5}, 16'hABCD);
    chk("R3 req", 16'(fl_req), 16'h1);
    chk("R3 erase op", 16'(fl_erase), 16'h1);
    chk("R3 page", 16'(fl_page), 16'h2);
    chk("R3 en held", 16'(en), 16'h1);
    chk("R4 busy set", 16'(busy), 16'h1);
    chk("R5 no stall rww", 16'(stall), 16'h0);
    buf_read(3'd0, w);
    chk("R3 erase leaves buffer", w, 16'h1111);
    cpu_read({4'd3, 3'd1}, 16'h1234);
    chk("R10 refused data", rd_data, BAD);
    chk("R10 refused flag", 16'(rd_viol), 16'h1);
    cpu_read({4'd14, 3'd2}, 16'h4321);
    chk("R10 nrww read data", rd_data, 16'h4321);
    chk("R10 nrww read flag", 16'(rd_viol), 16'h0);
    flash_finish(3);
    chk("R3 req dropped", 16'(fl_req), 16'h0);
    chk("R3 en cleared", 16'(en), 16'h0);
    chk("R4 busy sticky", 16'(busy), 16'h1);
    buf_read(3'd1, w);
    chk("R9 erase keeps buffer", w, 16'h2222);
    cpu_read({4'd3, 3'd0}, 16'h0F0F);
    chk("R10 still refused after done", 16'(rd_viol), 16'h1);

    // R4 R6 R9: re-enable with interrupt enable set
    ctl_write(8'h91);
    chk("R4 busy cleared", 16'(busy), 16'h0);
    tick();
    chk("R6 irq level", 16'(irq), 16'h1);
    cpu_read({4'd3, 3'd0}, 16'h0F0F);
    chk("R10 allowed read data", rd_data, 16'h0F0F);
    chk("R10 allowed read flag", 16'(rd_viol), 16'h0);
    buf_read(3'd1, w);
    chk("R9 re-enable clears buffer", w, 16'hFFFF);

    // R5 R6 R9: page write to no-read-while-write page 13
    issue(8'h01, 1, {4'd0, 3'd2}, 16'h7777);
    issue(8'h85, 2, {4'd13, 3'd0}, 16'h0000);
    chk("R5 stall", 16'(stall), 16'h1);
    chk("R5 busy untouched", 16'(busy), 16'h0);
    chk("R3 write op", 16'(fl_erase), 16'h0);
    chk("R3 write page", 16'(fl_page), 16'h000D);
    chk("R6 irq low in op", 16'(irq), 16'h0);
    buf_read(3'd2, w);
    chk("R8 buffer to array", w, 16'h7777);
    flash_finish(6);
    chk("R5 stall released", 16'(stall), 16'h0);
    chk("R3 en cleared write", 16'(en), 16'h0);
    tick();
    chk("R6 irq back", 16'(irq), 16'h1);
    buf_read(3'd2, w);
    chk("R9 write clears buffer", w, 16'hFFFF);

    // R7: lock bits only tighten
    issue(8'h09, 2, '0, 16'h0028);
    chk("R7 lock 1010", 16'(lock), 16'h000A);
    issue(8'h09, 1, '0, 16'h003C);
    chk("R7 no unprogram", 16'(lock), 16'h000A);
    issue(8'h89, 3, '0, 16'h0014);
    chk("R7 lock 0000", 16'(lock), 16'h0000);
    // R6: level holds over several cycles
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6 irq steady", 16'(irq), 16'h1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule